// File: doc/BRIEF.md
# Press-Length Switch Command Decoder

This block turns one bouncy, active-low push switch into three separate commands. The command is chosen by how long the switch is held. There is no debounce filter. Instead, the switch is looked at only on a slow sample strobe, about once per second, that lines up with a flashing heartbeat indicator. Contact bounce lasts far less than one strobe period, so it is never seen.

The user presses the switch and watches the heartbeat flash. Each strobe that finds the switch pressed adds one to a hold count, and the count stops at three. The first strobe that finds the switch released issues a single pulse, one clock wide, on one of three command lines, and clears the count. The whole block runs on the consumer's clock, and `sample_tick` is a one-cycle enable in that clock domain. A chip with several switches places one copy of the block per switch.

Top module: `switch_cmd_decoder`

## Requirements
- R1: After reset, `cmd_pulse` is all zero and the hold count is zero. A reset in the middle of a hold discards that hold, so the next release strobe issues no command.
- R2: The switch level counts only on a cycle where `sample_tick` is high. A press and release, or a glitch, that lies wholly between two strobes does not change the command that is issued. A command pulse only ever appears in the cycle right after a strobe.
- R3: A hold seen pressed on exactly one strobe issues `cmd_pulse[0]` on the next strobe that finds the switch released.
- R4: A hold seen pressed on exactly two strobes issues `cmd_pulse[1]` on the release strobe.
- R5: A hold seen pressed on three or more strobes issues `cmd_pulse[2]`. The hold count saturates at three and never wraps back to a shorter command.
- R6: At most one bit of `cmd_pulse` is high at any time, and each pulse lasts exactly one clock cycle.
- R7: Only the first released strobe after a hold issues a command. Later released strobes issue nothing until a new hold is seen.
- R8: No command is issued on a strobe that finds the switch pressed.
- R9: `sw_n` passes through a two-flop synchronizer. A level must be stable for two clock edges before the strobe edge to be seen by that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Consumer clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-cycle strobe, about 1 Hz, aligned with the heartbeat flash |
| sw_n | input | 1 | Raw switch level: 1 when idle, 0 when pressed |
| cmd_pulse | output | 3 | One-hot command pulse: bit 0 for a one-strobe hold, bit 1 for two strobes, bit 2 for three or more |

## Verification
If the hold count is wrong, the port shows it at once: the wrong bit of `cmd_pulse` rises in the cycle after the release strobe. Examples are a count that wraps past three, misses an increment, or survives a release or a reset. A count that is not cleared on release shows up one strobe later, as a second pulse where none should be. Sampling that is not gated by the strobe shows up as a glitch between strobes changing the command, or as a pulse with no strobe before it. The bench therefore checks the command lines in the cycle after every strobe, and again one cycle later.

// File: rtl/swcmd_pkg.sv
package swcmd_pkg;

  // Saturating increment used by the hold counter.
  function automatic int unsigned sat_inc(input int unsigned value,
                                          input int unsigned limit);
    if (value >= limit) return limit;
    return value + 1;
  endfunction

  // True when a hold count maps to the given command slot (slot 0 = one strobe).
  function automatic logic slot_hit(input int unsigned count,
                                    input int unsigned slot);
    return (count != 0) && (count == slot + 1);
  endfunction

endpackage

// File: rtl/swcmd_sync.sv
module swcmd_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) shift_q <= {STAGES{RST_VAL}};
    else        shift_q <= {shift_q[STAGES-2:0], d};
  end

  assign q = shift_q[STAGES-1];
endmodule

// File: rtl/swcmd_hold_counter.sv
module swcmd_hold_counter
  import swcmd_pkg::*;
#(
  parameter int MAX_HOLD = 3,
  localparam int CW = $clog2(MAX_HOLD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_tick,
  input  logic          sw_pressed,
  output logic [CW-1:0] hold_cnt,
  output logic          release_evt
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sample_tick) begin
      if (sw_pressed) cnt_q <= CW'(sat_inc(int'(cnt_q), MAX_HOLD));
      else            cnt_q <= '0;
    end
  end

  assign hold_cnt    = cnt_q;
  assign release_evt = sample_tick && !sw_pressed && (cnt_q != '0);
endmodule

// File: rtl/swcmd_pulse_encoder.sv
module swcmd_pulse_encoder
  import swcmd_pkg::*;
#(
  parameter int MAX_HOLD = 3,
  localparam int CW = $clog2(MAX_HOLD + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                release_evt,
  input  logic [CW-1:0]       hold_cnt,
  output logic [MAX_HOLD-1:0] cmd_q
);
  logic [MAX_HOLD-1:0] slot_sel;

  for (genvar i = 0; i < MAX_HOLD; i++) begin : g_slot
    assign slot_sel[i] = slot_hit(int'(hold_cnt), i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           cmd_q <= '0;
    else if (release_evt) cmd_q <= slot_sel;
    else                  cmd_q <= '0;
  end
endmodule

// File: rtl/switch_cmd_decoder.sv
module switch_cmd_decoder #(
  parameter int MAX_HOLD    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(MAX_HOLD + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_tick,
  input  logic                sw_n,
  output logic [MAX_HOLD-1:0] cmd_pulse
);
  // Named internal events, brought out for the bound checker.
  logic                sw_sync;
  logic                sw_pressed;
  logic [CW-1:0]       hold_cnt;
  logic                release_evt;
  logic [MAX_HOLD-1:0] cmd_vec;

  swcmd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sw_n), .q(sw_sync)
  );

  assign sw_pressed = ~sw_sync;

  swcmd_hold_counter #(.MAX_HOLD(MAX_HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .sw_pressed(sw_pressed), .hold_cnt(hold_cnt), .release_evt(release_evt)
  );

  swcmd_pulse_encoder #(.MAX_HOLD(MAX_HOLD)) u_enc (
    .clk(clk), .rst_n(rst_n), .release_evt(release_evt),
    .hold_cnt(hold_cnt), .cmd_q(cmd_vec)
  );

  assign cmd_pulse = cmd_vec;
endmodule

// File: rtl/swcmd_checker.sv
module swcmd_checker #(
  parameter int MAX_HOLD = 3,
  localparam int CW = $clog2(MAX_HOLD + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_tick,
  input logic                sw_pressed,
  input logic [CW-1:0]       hold_cnt,
  input logic [MAX_HOLD-1:0] cmd
);
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd));

  p_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd) |=> !(|cmd));

  p_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd) |-> $past(sample_tick));

  p_pressed_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && sw_pressed) |=> !(|cmd));

  p_release_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !sw_pressed) |=> (hold_cnt == '0));

  p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && sw_pressed && hold_cnt == CW'(MAX_HOLD)) |=> (hold_cnt == CW'(MAX_HOLD)));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> $stable(hold_cnt));
endmodule

bind switch_cmd_decoder swcmd_checker #(.MAX_HOLD(MAX_HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
  .sw_pressed(sw_pressed), .hold_cnt(hold_cnt), .cmd(cmd_vec)
);

// File: tb/switch_cmd_decoder_bench.sv
`timescale 1ns/1ps
module switch_cmd_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0;
  logic       sw_n = 1'b1;
  logic [2:0] cmd_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  switch_cmd_decoder u_switch_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .sw_n(sw_n), .cmd_pulse(cmd_pulse)
  );

  // Vector table: strobes seen pressed, glitch between strobes, expected command
  // (0 none, 1 one-strobe, 2 two-strobe, 3 long).
  localparam int NV = 7;
  localparam int HOLDS [NV] = '{1, 2, 3, 0, 6, 2, 1};
  localparam int GLITCH[NV] = '{0, 0, 0, 0, 0, 1, 1};
  localparam int EXPECT[NV] = '{1, 2, 3, 0, 3, 2, 1};

  function automatic logic [2:0] want(input int code);
    case (code)
      1: want = 3'b001;
      2: want = 3'b010;
      3: want = 3'b100;
      default: want = 3'b000;
    endcase
  endfunction

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: cmd_pulse=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Strobe for one cycle; sample the registered pulse one cycle later.
  task automatic tick_and_check(input logic [2:0] exp, input string req);
    @(negedge clk) sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
    check(cmd_pulse, exp, req);
    @(negedge clk);
    check(cmd_pulse, 3'b000, "R6 pulse lasts one cycle");
  endtask

  task automatic press_run(input int holds, input int glitch, input int code);
    sw_n = 1'b0;
    wait_clks(3);
    if (holds == 0) begin
      sw_n = 1'b1;               // R2: press wholly between strobes
      wait_clks(3);
    end
    for (int t = 0; t < holds; t++) begin
      tick_and_check(3'b000, "R8 no command while pressed");
      if (glitch != 0) begin
        sw_n = 1'b1; wait_clks(3); sw_n = 1'b0; wait_clks(3);   // R2 glitch
      end
    end
    sw_n = 1'b1;
    wait_clks(3);
    tick_and_check(want(code), code == 1 ? "R3 one-strobe hold" :
                               code == 2 ? "R4 two-strobe hold" :
                               code == 3 ? "R5 long hold saturates" : "R2 press between strobes");
    tick_and_check(3'b000, "R7 only first release strobe");
    wait_clks(2);
  endtask

  initial begin
    wait_clks(4);
    check(cmd_pulse, 3'b000, "R1 reset state");
    rst_n = 1'b1;
    wait_clks(2);
    check(cmd_pulse, 3'b000, "R1 after reset");
    tick_and_check(3'b000, "R1 idle strobe after reset");

    for (int v = 0; v < NV; v++) press_run(HOLDS[v], GLITCH[v], EXPECT[v]);

    // R1: reset in the middle of a two-strobe hold discards it.
    sw_n = 1'b0; wait_clks(3);
    tick_and_check(3'b000, "R8 pressed strobe");
    tick_and_check(3'b000, "R8 pressed strobe");
    rst_n = 1'b0; wait_clks(2); rst_n = 1'b1;
    sw_n = 1'b1; wait_clks(3);
    tick_and_check(3'b000, "R1 reset clears hold");

    // R9: a press only one edge before the strobe is not yet seen.
    @(negedge clk) begin sw_n = 1'b0; sample_tick = 1'b1; end
    @(negedge clk) sample_tick = 1'b0;
    wait_clks(3);
    sw_n = 1'b1; wait_clks(3);
    tick_and_check(3'b000, "R9 synchronizer latency");

    // R9: a press held two edges before the strobe is seen.
    sw_n = 1'b0; wait_clks(2);
    @(negedge clk) sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
    check(cmd_pulse, 3'b000, "R8 pressed strobe");
    sw_n = 1'b1; wait_clks(3);
    tick_and_check(3'b001, "R9 synced press counted");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule